// File: doc/BRIEF.md
# Diagnostic Line Wake-Up Pulse Generator

This block produces the fast-initialization wake-up pattern on the two single-wire diagnostic lines, K and L, before serial traffic begins on them. A start request carries a two-bit line-select code. While a selected line is being woken, the block takes it away from the UART transmit path and holds it low for a fixed time. Every few milliseconds during that low phase it lets the line go high for a single clock cycle. This keeps an external transceiver from tripping its dominant-state timeout. The block then hands the line back to the UART, which leaves it idle high, and waits for a guard interval. At the end of that interval it signals that the host may start communicating.

All times are measured against a free-running microsecond timestamp supplied by the system timebase. The block captures the timestamp at the start request and works out each elapsed time by modular subtraction from that captured value, so a timestamp that wraps around during a sequence does not disturb the timing. The low time, the glitch period and the completion time are parameters given in microsecond ticks. A sequence lasts about 50 ms with the default values.

Top module: `kline_wake_gen`

## Requirements
- R1: Select code 0 wakes line index 0 (K) only, code 1 wakes line index 1 (L) only, and code 2 wakes both lines. Bit i of `line_o` and `oe_o` belongs to line i.
- R2: From the cycle after the accepting clock edge, each selected line has `oe_o` high and is held low until the elapsed time since the captured start stamp reaches LOW_US.
- R3: While the low phase lasts, each selected line goes high for exactly one cycle whenever the elapsed time reaches a non-zero multiple of GLITCH_US below LOW_US. With the timestamp advancing by one per cycle, that gives (LOW_US-1)/GLITCH_US glitches.
- R4: Once the elapsed time reaches LOW_US, `oe_o` drops for every line and each line follows its `uart_tx_i` bit again.
- R5: `busy_o` is high from the cycle after acceptance until the elapsed time reaches DONE_US. In that cycle `busy_o` falls and `done_o` is high for exactly one cycle with `err_o` low.
- R6: A line that is not selected follows its `uart_tx_i` bit, with `oe_o` low, for the whole sequence.
- R7: A start request with select code 3 while idle drives no line and leaves `busy_o` low. In the next cycle it gives a one-cycle `done_o` together with `err_o`.
- R8: A start request made while `busy_o` is high is ignored. It changes neither the line selection nor the timing of the running sequence.
- R9: Elapsed times are computed modulo 2^TS_W, so a sequence whose timestamp wraps around through zero keeps the same timing.
- R10: While reset is asserted and afterwards until a start is accepted, `busy_o`, `done_o`, `err_o` and `oe_o` are low and each line follows `uart_tx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| sel_i | input | 2 | Line-select code (0 K, 1 L, 2 both, 3 invalid) |
| ts_i | input | TS_W | Free-running microsecond timestamp |
| uart_tx_i | input | 2 | UART transmit level per line |
| line_o | output | 2 | Line level: override value or UART level |
| oe_o | output | 2 | Per-line override active |
| busy_o | output | 1 | Wake-up sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Qualifies done_o for a rejected select code |

## Verification
The case hardest to reach from the ports is a sequence whose captured start stamp lies just below the timestamp wrap point. The elapsed values then cross zero partway through the low phase, and a wrong subtraction width would move the release, the glitches or the completion. The bench writes the timestamp directly to a value a few ticks before wrap-around while the block is idle, starts a sequence and checks every cycle against times computed from the captured stamp. To reach a start request that arrives mid-sequence, the bench raises the request during the low phase with a different select code, then confirms that the per-cycle pattern stays exactly that of the original selection.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int unsigned N_LINES = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_GUARD = 2'd2
  } wkp_state_e;

  function automatic logic [N_LINES-1:0] decode_sel(input logic [1:0] code);
    logic [N_LINES-1:0] m;
    case (code)
      2'd0:    m = 2'b01;
      2'd1:    m = 2'b10;
      2'd2:    m = 2'b11;
      default: m = 2'b00;
    endcase
    return m;
  endfunction

  function automatic logic sel_valid(input logic [1:0] code);
    return code <= 2'd2;
  endfunction
endpackage

// File: rtl/wkp_elapsed.sv
module wkp_elapsed #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] elapsed_o
);
  logic [TS_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        start_q <= '0;
    else if (capture_i) start_q <= ts_i;
  end

  // modular difference, wrap safe
  assign elapsed_o = ts_i - start_q;

  // R9
  elapsed_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (elapsed_o == TS_W'(ts_i - $past(ts_i))));
endmodule

// File: rtl/wkp_glitch.sv
module wkp_glitch #(
  parameter int unsigned TS_W      = 32,
  parameter int unsigned GLITCH_US = 5000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            run_i,
  input  logic [TS_W-1:0] elapsed_i,
  output logic            pulse_o
);
  logic [TS_W-1:0] mark_q;
  logic [TS_W-1:0] since_mark;

  assign since_mark = elapsed_i - mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mark_q  <= '0;
      pulse_o <= 1'b0;
    end else if (clear_i) begin
      mark_q  <= '0;
      pulse_o <= 1'b0;
    end else if (run_i && (since_mark >= TS_W'(GLITCH_US))) begin
      mark_q  <= elapsed_i;
      pulse_o <= 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R3
  glitch_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R3
  glitch_only_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(run_i));
endmodule

// File: rtl/wkp_ctrl.sv
module wkp_ctrl
  import wkp_pkg::*;
#(
  parameter int unsigned TS_W    = 32,
  parameter int unsigned LOW_US  = 25000,
  parameter int unsigned DONE_US = 49000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         sel_i,
  input  logic [TS_W-1:0]    elapsed_i,
  output logic               capture_o,
  output logic               low_run_o,
  output logic [N_LINES-1:0] drive_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  wkp_state_e         state_q;
  logic [N_LINES-1:0] mask_q;
  logic               low_over;
  logic               guard_over;

  assign low_over   = elapsed_i >= TS_W'(LOW_US);
  assign guard_over = elapsed_i >= TS_W'(DONE_US);
  assign capture_o  = (state_q == ST_IDLE) && start_i && sel_valid(sel_i);
  assign low_run_o  = (state_q == ST_LOW) && !low_over;
  assign drive_o    = (state_q == ST_LOW) ? mask_q : '0;
  assign busy_o     = state_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (sel_valid(sel_i)) begin
              mask_q  <= decode_sel(sel_i);
              state_q <= ST_LOW;
            end else begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (low_over) state_q <= ST_GUARD;
        end
        ST_GUARD: begin
          if (guard_over) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  bad_sel_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && sel_i == 2'd3) |=> (done_o && err_o && !busy_o));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW && start_i) |=> $stable(mask_q));

  // R2
  release_at_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW && low_over) |=> (state_q == ST_GUARD && drive_o == '0));

  // R5
  done_after_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ($past(state_q) == ST_GUARD && !busy_o));

  // R1
  mask_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mask_q != '0));
endmodule

// File: rtl/wkp_line.sv
module wkp_line (
  input  logic drive_i,
  input  logic level_i,
  input  logic uart_tx_i,
  output logic line_o,
  output logic oe_o
);
  assign oe_o   = drive_i;
  assign line_o = drive_i ? level_i : uart_tx_i;
endmodule

// File: rtl/kline_wake_gen.sv
module kline_wake_gen
  import wkp_pkg::*;
#(
  parameter int unsigned TS_W      = 32,
  parameter int unsigned LOW_US    = 25000,
  parameter int unsigned GLITCH_US = 5000,
  parameter int unsigned DONE_US   = 49000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      sel_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic [1:0]      uart_tx_i,
  output logic [1:0]      line_o,
  output logic [1:0]      oe_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);
  logic [TS_W-1:0]    elapsed;
  logic               capture;
  logic               low_run;
  logic               glitch;
  logic [N_LINES-1:0] drive;

  wkp_elapsed #(.TS_W(TS_W)) u_elapsed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .ts_i      (ts_i),
    .elapsed_o (elapsed)
  );

  wkp_ctrl #(.TS_W(TS_W), .LOW_US(LOW_US), .DONE_US(DONE_US)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sel_i     (sel_i),
    .elapsed_i (elapsed),
    .capture_o (capture),
    .low_run_o (low_run),
    .drive_o   (drive),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  wkp_glitch #(.TS_W(TS_W), .GLITCH_US(GLITCH_US)) u_glitch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (capture),
    .run_i     (low_run),
    .elapsed_i (elapsed),
    .pulse_o   (glitch)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    wkp_line u_line (
      .drive_i   (drive[i]),
      .level_i   (glitch),
      .uart_tx_i (uart_tx_i[i]),
      .line_o    (line_o[i]),
      .oe_o      (oe_o[i])
    );
  end

  // R4
  oe_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o != '0) |-> busy_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (oe_o == '0));
endmodule

// File: tb/kline_wake_gen_tb_top.sv
`timescale 1ns/1ps
module kline_wake_gen_tb_top;
  localparam int unsigned TS_W   = 32;
  localparam int unsigned LOW_T  = 250;
  localparam int unsigned GLT_T  = 50;
  localparam int unsigned DONE_T = 490;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      sel = 2'd0;
  logic [TS_W-1:0] ts = '0;
  logic [1:0]      uart_tx = 2'b11;
  logic [1:0]      line, oe;
  logic            busy, done, err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // timestamp advances on falling edges
  initial forever begin
    @(negedge clk);
    ts = ts + 1'b1;
  end

  kline_wake_gen #(.TS_W(TS_W), .LOW_US(LOW_T), .GLITCH_US(GLT_T), .DONE_US(DONE_T)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .sel_i(sel), .ts_i(ts),
    .uart_tx_i(uart_tx), .line_o(line), .oe_o(oe),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick_sample();
    @(posedge clk);
    #2;
  endtask

  // full wake-up sequence; optional late start during the low phase
  task automatic run_wake(input logic [1:0] code, input bit late_start);
    logic [1:0]      m;
    logic [TS_W-1:0] t0, el;
    int e_oe, e_lvl, e_uart, e_busy, e_done, glitches, first_rel, done_at;
    m = (code == 2'd0) ? 2'b01 : (code == 2'd1) ? 2'b10 : 2'b11;
    e_oe = 0; e_lvl = 0; e_uart = 0; e_busy = 0; e_done = 0;
    glitches = 0; first_rel = -1; done_at = -1;
    sel = code;
    start = 1'b1;
    tick_sample();
    start = 1'b0;
    t0 = ts;
    for (int k = 0; k <= int'(DONE_T) + 3; k++) begin
      el = ts - t0;
      for (int i = 0; i < 2; i++) begin
        if (m[i]) begin
          bit in_low, exp_g;
          in_low = el < LOW_T;
          exp_g  = in_low && el != 0 && (el % GLT_T) == 0;
          if (oe[i] !== in_low) e_oe++;
          if (in_low) begin
            if (line[i] !== exp_g) e_lvl++;
            if (line[i] === 1'b1) glitches++;
          end else begin
            if (line[i] !== uart_tx[i]) e_lvl++;
            if (first_rel < 0 && i == (m[0] ? 0 : 1)) first_rel = int'(el);
          end
        end else begin
          if (oe[i] !== 1'b0 || line[i] !== uart_tx[i]) e_uart++;
        end
      end
      if (busy !== (el < DONE_T)) e_busy++;
      if (done !== (el == DONE_T)) e_done++;
      if (done === 1'b1 && done_at < 0) done_at = int'(el);
      if (done === 1'b1 && err !== 1'b0) e_done++;
      uart_tx = el[1:0];
      if (late_start && el == 100) begin
        sel = (code == 2'd0) ? 2'd1 : 2'd0;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      tick_sample();
    end
    start = 1'b0;
    check(e_oe == 0, "R2", $sformatf("oe pattern sel=%0d", code), e_oe, 0);
    check(e_lvl == 0, "R4", $sformatf("line level sel=%0d", code), e_lvl, 0);
    check(glitches == int'(((LOW_T - 1) / GLT_T) * $countones(m)), "R3",
          $sformatf("glitch count sel=%0d", code), glitches,
          ((LOW_T - 1) / GLT_T) * $countones(m));
    check(first_rel == int'(LOW_T), "R2", $sformatf("release time sel=%0d", code),
          first_rel, LOW_T);
    check(e_uart == 0, "R6", $sformatf("unselected line sel=%0d", code), e_uart, 0);
    check(e_busy == 0, "R5", $sformatf("busy window sel=%0d", code), e_busy, 0);
    check(e_done == 0 && done_at == int'(DONE_T), "R5",
          $sformatf("done time sel=%0d", code), done_at, DONE_T);
    if (late_start)
      check(e_oe == 0 && e_uart == 0 && done_at == int'(DONE_T), "R8",
            "late start ignored", e_oe + e_uart, 0);
  endtask

  task automatic run_reset_check();
    uart_tx = 2'b10;
    #1;
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10", "status in reset",
          {busy, done, err}, 0);
    check(oe === 2'b00 && line === uart_tx, "R10", "lines in reset", {oe, line}, {2'b00, uart_tx});
    rst_ni = 1'b1;
    tick_sample();
    tick_sample();
    check(busy === 1'b0 && oe === 2'b00 && line === uart_tx, "R10", "idle after reset",
          {busy, oe, line}, {1'b0, 2'b00, uart_tx});
  endtask

  task automatic run_bad_sel();
    uart_tx = 2'b01;
    sel = 2'd3;
    start = 1'b1;
    tick_sample();
    start = 1'b0;
    check(done === 1'b1 && err === 1'b1 && busy === 1'b0, "R7", "reject pulse",
          {done, err, busy}, 3'b110);
    check(oe === 2'b00 && line === uart_tx, "R7", "no drive on reject", {oe, line}, {2'b00, uart_tx});
    tick_sample();
    check(done === 1'b0 && err === 1'b0 && busy === 1'b0, "R7", "reject one cycle",
          {done, err, busy}, 0);
  endtask

  task automatic run_wrap();
    @(posedge clk);
    #1;
    ts = '1 - TS_W'(120);
    tick_sample();
    run_wake(2'd2, 1'b0);
    check(ts < TS_W'(DONE_T), "R9", "timestamp wrapped", ts, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    run_reset_check();
    run_wake(2'd0, 1'b0);   // R1 K only
    tick_sample();
    run_wake(2'd1, 1'b0);   // R1 L only
    tick_sample();
    run_wake(2'd2, 1'b0);   // R1 both
    tick_sample();
    run_bad_sel();
    tick_sample();
    run_wake(2'd1, 1'b1);   // R8 start while busy
    tick_sample();
    run_wrap();             // R9
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule